// File: doc/BRIEF.md
# Dual-Mode Microprocessor Register Bus Slave

This block sits between an external microprocessor bus and the register file of a peripheral with an 8-bit register address space. One static mode input chooses the strobe convention. In the separate-strobe convention, a read strobe and a write strobe each qualify an access. In the direction-line convention, one data strobe qualifies every access and a direction line selects read or write. A second static mode input chooses how the address arrives. On a multiplexed bus the address is captured by an address latch enable, so no external latch is needed. On a demultiplexed bus the address lines are used directly and the latch enable is held high.

All bus inputs are asynchronous. They pass through a synchronizer chain into the internal clock domain before any edge detection. A write is committed once, as a single-cycle write-enable pulse, when the end of the strobe is detected. A read raises a single-cycle read-enable pulse at the start of the strobe and registers the returned value onto the output data bus. The data-bus output enable follows the synchronized read condition. It is released one clock after either chip select or the read condition goes away.

Top module: `upbus_slave`

## Requirements
- R1: While reset is low and in the first cycles after its release, `reg_we`, `reg_re` and `bus_data_oe` are 0.
- R2: Separate-strobe read (mode_moto_i=0): with `bus_cs_n`=0 and `bus_rdds_n`=0, `bus_data_oe` rises and `bus_data_out` shows the content of the register at the access address.
- R3: Separate-strobe write (mode_moto_i=0): with `bus_cs_n`=0, a low level on `bus_wrdir` is the write strobe. When it ends, `reg_we` pulses once, carrying the access address on `reg_addr` and the last sampled `bus_data_in` on `reg_wdata`.
- R4: Direction-line mode (mode_moto_i=1): `bus_rdds_n`=0 with `bus_cs_n`=0 qualifies an access. `bus_wrdir`=1 makes it a read and `bus_wrdir`=0 makes it a write, each with the effects of R2/R3.
- R5: Multiplexed mode (mode_mux_i=1): the access address is the value `bus_addr` had in the last synchronized sample before `bus_ale` fell. Changes on `bus_addr` while `bus_ale` stays low are ignored.
- R6: Demultiplexed mode (mode_mux_i=0, `bus_ale` held 1): the access address is taken directly from `bus_addr`.
- R7: Strobes while `bus_cs_n`=1 cause no write, no read pulse and no output enable.
- R8: Each strobe assertion gives exactly one `reg_we` pulse (for a write) or one `reg_re` pulse (for a read), whatever the strobe length.
- R9: `bus_data_oe` equals the read condition delayed by SYNC_STAGES+1 clocks, so it drops one clock after the synchronized read condition ends.
- R10: The mode inputs are captured at reset. Changing them later does not change how strobes are decoded or how the address is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low; mode inputs are captured here |
| mode_moto_i | input | 1 | 0 = separate read/write strobes, 1 = data strobe plus direction line |
| mode_mux_i | input | 1 | 1 = multiplexed address captured by latch enable, 0 = direct address |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rdds_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| bus_wrdir | input | 1 | Write strobe active low (mode 0) or direction, 1 = read (mode 1) |
| bus_ale | input | 1 | Address latch enable, address captured as it falls |
| bus_addr | input | ADDR_W | Address lines |
| bus_data_in | input | DATA_W | Data bus, input side |
| bus_data_out | output | DATA_W | Data bus, output side |
| bus_data_oe | output | 1 | Data bus output enable |
| reg_addr | output | ADDR_W | Register file address |
| reg_wdata | output | DATA_W | Register file write data |
| reg_we | output | 1 | Register file write enable, single-cycle pulse |
| reg_re | output | 1 | Register file read enable, single-cycle pulse |
| reg_rdata | input | DATA_W | Register file read data, combinational from `reg_addr` |

## Verification
The bench builds the block with 8-bit address and data and two synchronizer stages. It runs all four combinations of strobe convention and address handling, each after its own reset. The full 256-entry address space then fits in the bench's register file, which lets a write followed by a read-back at the same address be checked end to end. With the short synchronizer chain, long strobes, strobes without chip select, and address lines changed after the latch enable fell all finish in a few cycles, so each can be compared clock by clock against the reference model.

// File: rtl/upbus_pkg.sv
package upbus_pkg;

  typedef struct packed {
    logic cs_n;
    logic rdds_n;
    logic wrdir;
    logic ale;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{cs_n: 1'b1, rdds_n: 1'b1, wrdir: 1'b1, ale: 1'b1};

  // read condition for either strobe convention
  function automatic logic is_read(bus_ctl_t c, logic moto);
    if (moto) return !c.cs_n && !c.rdds_n && c.wrdir;
    return !c.cs_n && !c.rdds_n;
  endfunction

  // write condition for either strobe convention
  function automatic logic is_write(bus_ctl_t c, logic moto);
    if (moto) return !c.cs_n && !c.rdds_n && !c.wrdir;
    return !c.cs_n && !c.wrdir;
  endfunction

endpackage

// File: rtl/upbus_sync.sv
module upbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/upbus_addr_sel.sv
module upbus_addr_sel #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode,
  input  logic              ale_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic [ADDR_W-1:0] latch_q,
  output logic [ADDR_W-1:0] eff_addr
);
  // follows the address while ALE is high, freezes on its fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= '0;
    else if (ale_s) latch_q <= addr_s;
  end

  assign eff_addr = mux_mode ? latch_q : addr_s;
endmodule

// File: rtl/upbus_access.sv
module upbus_access #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [DATA_W-1:0] wdata_s,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic [DATA_W-1:0] dout,
  output logic              oe,
  output logic              rd_start,
  output logic              wr_end
);
  logic rd_q, wr_q;

  assign rd_start = rd_act & ~rd_q;
  assign wr_end   = wr_q & ~wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      dout      <= '0;
      oe        <= 1'b0;
    end else begin
      rd_q   <= rd_act;
      wr_q   <= wr_act;
      reg_we <= wr_end;
      reg_re <= rd_start;
      oe     <= rd_act;
      if (rd_start || wr_act) reg_addr <= eff_addr;
      if (wr_act) reg_wdata <= wdata_s;
      if (reg_re) dout <= reg_rdata;
    end
  end
endmodule

// File: rtl/upbus_slave.sv
module upbus_slave #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_moto_i,
  input  logic              mode_mux_i,
  input  logic              bus_cs_n,
  input  logic              bus_rdds_n,
  input  logic              bus_wrdir,
  input  logic              bus_ale,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  import upbus_pkg::*;

  localparam int CTL_W = $bits(bus_ctl_t);

  // mode capture: follows the inputs until the first clock after reset
  logic running;
  logic moto_q, mux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!running) begin
      moto_q <= mode_moto_i;
      mux_q  <= mode_mux_i;
    end
  end

  // synchronizers
  bus_ctl_t          ctl_raw, ctl_s;
  logic [CTL_W-1:0]  ctl_s_vec;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  assign ctl_raw = '{cs_n: bus_cs_n, rdds_n: bus_rdds_n, wrdir: bus_wrdir, ale: bus_ale};

  upbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s_vec));
  assign ctl_s = bus_ctl_t'(ctl_s_vec);

  upbus_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(bus_addr), .q(addr_s));

  upbus_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(bus_data_in), .q(data_s));

  // decode (named for the checker)
  logic rd_act, wr_act;
  assign rd_act = running && is_read(ctl_s, moto_q);
  assign wr_act = running && is_write(ctl_s, moto_q);

  logic [ADDR_W-1:0] latch_q, eff_addr;
  upbus_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_q), .ale_s(ctl_s.ale),
    .addr_s(addr_s), .latch_q(latch_q), .eff_addr(eff_addr));

  logic rd_start, wr_end;
  upbus_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .wr_act(wr_act),
    .eff_addr(eff_addr), .wdata_s(data_s), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .dout(bus_data_out), .oe(bus_data_oe), .rd_start(rd_start), .wr_end(wr_end));
endmodule

// File: rtl/upbus_slave_chk.sv
module upbus_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_re,
  input logic              oe,
  input logic              rd_act,
  input logic              wr_end,
  input logic              mux_q,
  input logic              ale_s,
  input logic [ADDR_W-1:0] latch_q,
  input logic [DATA_W-1:0] reg_wdata
);
  // R3
  write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_end |=> reg_we);
  // R8
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we);
  // R8
  re_single_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_re |=> !reg_re);
  // R9
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_act |=> !oe);
  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_re |-> oe |=> oe);
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_q && !ale_s) |=> $stable(latch_q));
  // R3
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> $stable(reg_wdata));
endmodule

bind upbus_slave upbus_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .oe(bus_data_oe),
  .rd_act(rd_act), .wr_end(wr_end), .mux_q(mux_q), .ale_s(ctl_s.ale),
  .latch_q(latch_q), .reg_wdata(reg_wdata));

// File: tb/upbus_slave_tb.sv
`timescale 1ns/1ps
module upbus_slave_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SS = 2;
  localparam int RAW_W = 4 + AW + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_moto_i = 1'b0, mode_mux_i = 1'b0;
  logic bus_cs_n = 1'b1, bus_rdds_n = 1'b1, bus_wrdir = 1'b1, bus_ale = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data_in = '0;
  logic [DW-1:0] bus_data_out, reg_wdata, reg_rdata;
  logic [AW-1:0] reg_addr;
  logic bus_data_oe, reg_we, reg_re;

  always #5 clk = ~clk;

  upbus_slave #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_moto_i(mode_moto_i), .mode_mux_i(mode_mux_i),
    .bus_cs_n(bus_cs_n), .bus_rdds_n(bus_rdds_n), .bus_wrdir(bus_wrdir), .bus_ale(bus_ale),
    .bus_addr(bus_addr), .bus_data_in(bus_data_in), .bus_data_out(bus_data_out),
    .bus_data_oe(bus_data_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata));

  // external register file
  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_mem [256];
  initial for (int i = 0; i < 256; i++) begin mem[i] = DW'(i) ^ 8'h5A; exp_mem[i] = DW'(i) ^ 8'h5A; end
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;
  assign reg_rdata = mem[reg_addr];

  integer n_cmp = 0, n_bad = 0, cyc = 0, we_cnt = 0, re_cnt = 0;

  task automatic check(input bit ok, input string req, input string what, input integer act, input integer exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: inputs seen SS edges ago, pulses, latch
  logic [RAW_W-1:0] hist [SS];
  bit m_moto, m_mux, m_first;
  bit m_we, m_re, m_oe, m_wrp, m_rdp;
  logic [AW-1:0] m_addr, m_latch;
  logic [DW-1:0] m_wdata, m_dout;

  always @(posedge clk) begin
    cyc++;
    if (reg_we) we_cnt++;
    if (reg_re) re_cnt++;
    if (!rst_n) begin
      for (int i = 0; i < SS; i++) hist[i] = {4'b1111, {AW{1'b0}}, {DW{1'b0}}};
      m_we = 0; m_re = 0; m_oe = 0; m_wrp = 0; m_rdp = 0;
      m_addr = '0; m_latch = '0; m_wdata = '0; m_dout = '0;
      m_moto = mode_moto_i; m_mux = mode_mux_i; m_first = 1;
    end else begin
      logic [RAW_W-1:0] s;
      bit cs, ds, wd, al, rd, wr, n_we, n_re;
      logic [AW-1:0] sa, eff;
      logic [DW-1:0] sd;
      if (m_first) begin m_moto = mode_moto_i; m_mux = mode_mux_i; m_first = 0; end
      s = hist[SS-1];
      {cs, ds, wd, al} = s[RAW_W-1 -: 4];
      sa = s[AW+DW-1 -: AW];
      sd = s[DW-1:0];
      rd = m_moto ? (!cs && !ds && wd) : (!cs && !ds);
      wr = m_moto ? (!cs && !ds && !wd) : (!cs && !wd);
      eff = m_mux ? m_latch : sa;
      n_we = m_wrp && !wr;
      n_re = rd && !m_rdp;
      if (m_re) m_dout = mem[m_addr];
      if (n_re || wr) m_addr = eff;
      if (wr) m_wdata = sd;
      if (al) m_latch = sa;
      m_we = n_we; m_re = n_re; m_oe = rd; m_wrp = wr; m_rdp = rd;
      for (int i = SS-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {bus_cs_n, bus_rdds_n, bus_wrdir, bus_ale, bus_addr, bus_data_in};
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(bus_data_oe == m_oe, "R9", "oe", bus_data_oe, m_oe);
    check(reg_we == m_we, "R3", "reg_we", reg_we, m_we);
    check(reg_re == m_re, "R8", "reg_re", reg_re, m_re);
    check(reg_addr == m_addr, m_mux ? "R5" : "R6", "reg_addr", reg_addr, m_addr);
    check(reg_wdata == m_wdata, "R3", "reg_wdata", reg_wdata, m_wdata);
    check(bus_data_out == m_dout, "R2", "data_out", bus_data_out, m_dout);
  end

  task automatic wait_n(input integer n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit moto, input bit mux);
    @(negedge clk);
    rst_n = 0; mode_moto_i = moto; mode_mux_i = mux;
    bus_cs_n = 1; bus_rdds_n = 1; bus_wrdir = 1; bus_ale = 1;
    wait_n(3);
    // R1
    check(!bus_data_oe && !reg_we && !reg_re, "R1", "idle in reset", {bus_data_oe, reg_we, reg_re}, 0);
    rst_n = 1;
    wait_n(1);
    check(!bus_data_oe && !reg_we && !reg_re, "R1", "idle after reset", {bus_data_oe, reg_we, reg_re}, 0);
    wait_n(3);
  endtask

  task automatic addr_phase(input logic [AW-1:0] a);
    if (mode_mux_i || dut_mux()) begin
      bus_addr = a; bus_ale = 1; wait_n(3);
      bus_ale = 0; wait_n(3);
      bus_addr = ~a;  // R5: later address changes ignored
    end else begin
      bus_ale = 1; bus_addr = a;
    end
  endtask

  bit cur_mux, cur_moto;
  function automatic bit dut_mux(); return cur_mux; endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input integer len, input bit sel);
    addr_phase(a);
    bus_data_in = d;
    bus_cs_n = !sel;
    if (cur_moto) begin bus_wrdir = 0; wait_n(1); bus_rdds_n = 0; wait_n(len); bus_rdds_n = 1; wait_n(1); bus_wrdir = 1; end
    else begin wait_n(1); bus_wrdir = 0; wait_n(len); bus_wrdir = 1; wait_n(1); end
    bus_cs_n = 1;
    wait_n(6);
    if (sel) exp_mem[a] = d;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input integer len, input bit sel, input string req);
    addr_phase(a);
    bus_cs_n = !sel;
    bus_wrdir = 1;
    wait_n(1); bus_rdds_n = 0;
    wait_n(len);
    if (sel) begin
      check(bus_data_oe == 1'b1, req, "oe during read", bus_data_oe, 1);
      check(bus_data_out == exp_mem[a], req, "read data", bus_data_out, exp_mem[a]);
    end else begin
      check(bus_data_oe == 1'b0, "R7", "oe without cs", bus_data_oe, 0);
    end
    bus_rdds_n = 1; wait_n(1); bus_cs_n = 1;
    wait_n(SS + 2);
    check(bus_data_oe == 1'b0, "R9", "oe released", bus_data_oe, 0);
    wait_n(2);
  endtask

  task automatic run_phase(input bit moto, input bit mux, input logic [7:0] seed);
    integer w0, r0;
    cur_moto = moto; cur_mux = mux;
    do_reset(moto, mux);
    bus_write(seed, seed ^ 8'hC3, 2, 1);
    bus_read(seed, 7, 1, moto ? "R4" : "R2");
    bus_write(8'hFF, seed + 8'd1, 1, 1);
    bus_write(8'h00, seed + 8'd2, 3, 1);
    bus_read(8'hFF, 6, 1, mux ? "R5" : "R6");
    bus_read(8'h00, 6, 1, mux ? "R5" : "R6");
    // R8: long strobes give one pulse each
    w0 = we_cnt;
    bus_write(seed + 8'd9, 8'h77, 20, 1);
    check(we_cnt - w0 == 1, "R8", "writes per long strobe", we_cnt - w0, 1);
    r0 = re_cnt;
    bus_read(seed + 8'd9, 20, 1, "R8");
    check(re_cnt - r0 == 1, "R8", "reads per long strobe", re_cnt - r0, 1);
    // R7: no chip select
    w0 = we_cnt;
    bus_write(seed + 8'd9, 8'h11, 4, 0);
    check(we_cnt == w0, "R7", "write without cs", we_cnt - w0, 0);
    r0 = re_cnt;
    bus_read(seed + 8'd9, 5, 0, "R7");
    check(re_cnt == r0, "R7", "read pulse without cs", re_cnt - r0, 0);
    bus_read(seed + 8'd9, 6, 1, "R7");
    // R10: flip mode inputs mid-run, decoding must not follow
    mode_moto_i = !moto; mode_mux_i = !mux;
    bus_write(seed + 8'd20, 8'hA5, 3, 1);
    bus_read(seed + 8'd20, 6, 1, "R10");
    mode_moto_i = moto; mode_mux_i = mux;
  endtask

  initial begin
    run_phase(0, 0, 8'h12);
    run_phase(0, 1, 8'h34);
    run_phase(1, 0, 8'h56);
    run_phase(1, 1, 8'h78);
    wait_n(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) if (cyc == 150000) begin
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule